// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Clear-to-Send Gating

This block turns bytes into an asynchronous serial bit stream. Bytes come in through a valid/ready handshake, each with an optional multiprocessor flag. The block serialises one frame at a time on a single output line, which rests at 1 between frames. A baud tick enable from an external rate generator sets the bit timing. Every bit lasts a fixed number of ticks.

Three configuration inputs shape each frame. One inserts a ninth multiprocessor bit in the slot that parity would otherwise use. One selects one or two stop bits. One turns on flow control through a clear-to-send input. When flow control is on, the clear-to-send level is registered every system clock. A new character may begin only if the registered value shows permission. A character that has already started always runs to its final stop bit, whatever the clear-to-send input does meanwhile.

Top module: `uart_tx_cts`

## Requirements
- R1: While reset is asserted and after it is released, tx_o is 1 and no frame is in progress.
- R2: A frame is one start bit at 0, then data bits 0 through 7 in that order (LSB first), then the stop bit(s) at 1; after the stop bit(s) the line returns to 1.
- R3: Every bit lasts exactly 16 cycles in which baud_tick_i is high; without ticks, tx_o does not change.
- R4: With mp_en_i set, the mp_i bit of the byte is sent immediately after data bit 7 and before the stop bit(s).
- R5: With two_stop_i set, the frame carries two stop bits; otherwise it carries one.
- R6: ready_o is high only while no frame is in progress; a byte is taken in the cycle where valid_i and ready_o are both high, and the start bit appears on tx_o in the following cycle.
- R7: With cts_en_i set, ready_o depends on the value of cts_i registered at the previous clock edge; while that value is 0, no byte is taken and the line stays at 1.
- R8: A deassertion of cts_i during a frame does not alter or shorten that frame.
- R9: With cts_en_i clear, cts_i has no effect on ready_o or tx_o.
- R10: When a byte is waiting and sending is permitted, the next byte is taken in the cycle right after the last stop bit ends, so the next start bit follows one system clock later.
- R11: mp_en_i and two_stop_i are captured when a byte is taken; changing them during a frame does not affect that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| baud_tick_i | input | 1 | Baud tick enable, 16 per bit |
| data_i | input | 8 | Byte to send |
| mp_i | input | 1 | Multiprocessor bit for this byte |
| valid_i | input | 1 | Byte on data_i/mp_i is offered |
| ready_o | output | 1 | Block can accept a byte this cycle |
| cts_en_i | input | 1 | Enable clear-to-send gating |
| mp_en_i | input | 1 | Insert the multiprocessor bit |
| two_stop_i | input | 1 | Send two stop bits instead of one |
| cts_i | input | 1 | Clear to send, 1 = permitted |
| tx_o | output | 1 | Serial line |

## Verification
Two events can fall in the same cycle and interact: the end of the last stop bit, and a clear-to-send change or configuration change that arrives just as the next byte is offered. The bench drives random baud ticks, random valid, random cts_i and configuration bits that change on any cycle. It compares tx_o and ready_o on every clock against a behavioural model. The model builds each frame as a bit queue at acceptance and gates the start on the cts value of the previous clock. Directed cases also deassert clear-to-send in the middle of a frame and hold valid high across two frames, then check the recovered bit sequence and the gap between the two acceptances.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_MP,
    ST_STOP
  } tx_state_e;
endpackage

// File: rtl/uart_tx_tick_ctr.sv
module uart_tx_tick_ctr #(
  parameter int TICKS_PER_BIT = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic run_i,
  input  logic tick_i,
  output logic bit_end_o
);
  localparam int CW = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS_PER_BIT - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (clr_i || !run_i)     cnt_q <= '0;
    else if (tick_i)              cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  assign bit_end_o = run_i && tick_i && (cnt_q == LAST);

  // R3
  no_tick_no_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |-> !bit_end_o);
endmodule

// File: rtl/uart_tx_cts_gate.sv
module uart_tx_cts_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cts_en_i,
  input  logic cts_i,
  output logic go_o
);
  logic cts_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cts_q <= 1'b0;
    else         cts_q <= cts_i;
  end

  // pin only matters when gating is enabled
  assign go_o = !cts_en_i || cts_q;

  // R7
  cts_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cts_en_i && !$past(cts_i)) |-> !go_o);
endmodule

// File: rtl/uart_tx_cts.sv
module uart_tx_cts #(
  parameter int DATA_W        = 8,
  parameter int TICKS_PER_BIT = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              baud_tick_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              mp_i,
  input  logic              valid_i,
  output logic              ready_o,
  input  logic              cts_en_i,
  input  logic              mp_en_i,
  input  logic              two_stop_i,
  input  logic              cts_i,
  output logic              tx_o
);
  import uart_tx_pkg::*;

  localparam int IW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [IW-1:0] LAST_IDX = IW'(DATA_W - 1);

  tx_state_e         state_q;
  logic [DATA_W-1:0] shreg_q;
  logic [IW-1:0]     idx_q;
  logic              mp_q, mp_en_q, two_q, stop2_q;
  logic              go, accept, bit_end, busy;

  assign busy    = (state_q != ST_IDLE);
  assign ready_o = !busy && go;
  assign accept  = valid_i && ready_o;

  uart_tx_cts_gate u_gate (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cts_en_i (cts_en_i),
    .cts_i    (cts_i),
    .go_o     (go)
  );

  uart_tx_tick_ctr #(.TICKS_PER_BIT(TICKS_PER_BIT)) u_ctr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (accept),
    .run_i     (busy),
    .tick_i    (baud_tick_i),
    .bit_end_o (bit_end)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      shreg_q <= '0;
      idx_q   <= '0;
      mp_q    <= 1'b0;
      mp_en_q <= 1'b0;
      two_q   <= 1'b0;
      stop2_q <= 1'b0;
    end else if (accept) begin
      state_q <= ST_START;
      shreg_q <= data_i;
      mp_q    <= mp_i;
      mp_en_q <= mp_en_i;
      two_q   <= two_stop_i;
      idx_q   <= '0;
      stop2_q <= 1'b0;
    end else if (bit_end) begin
      unique case (state_q)
        ST_START: state_q <= ST_DATA;
        ST_DATA: begin
          shreg_q <= shreg_q >> 1;
          idx_q   <= idx_q + 1'b1;
          if (idx_q == LAST_IDX) state_q <= mp_en_q ? ST_MP : ST_STOP;
        end
        ST_MP: state_q <= ST_STOP;
        ST_STOP: begin
          if (two_q && !stop2_q) stop2_q <= 1'b1;
          else                   state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    unique case (state_q)
      ST_START: tx_o = 1'b0;
      ST_DATA:  tx_o = shreg_q[0];
      ST_MP:    tx_o = mp_q;
      default:  tx_o = 1'b1;
    endcase
  end

  // R6
  ready_idle_line_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> tx_o);

  // R6
  start_after_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ready_o) |=> (!tx_o && !ready_o));

  // R3
  hold_without_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!baud_tick_i && !ready_o && !(valid_i && ready_o) && $past(1'b1)) |=> $stable(tx_o));

  // R8
  frame_not_cut_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && !bit_end) |=> !ready_o);
endmodule

// File: tb/uart_tx_cts_tb.sv
module uart_tx_cts_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, valid = 1'b0, mp = 1'b0;
  logic cts_en = 1'b0, mp_en = 1'b0, two = 1'b0, cts = 1'b0;
  logic [7:0] data = 8'h00;
  logic ready, tx;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  uart_tx_cts u_dut (
    .clk_i(clk), .rst_ni(rst_n), .baud_tick_i(tick), .data_i(data),
    .mp_i(mp), .valid_i(valid), .ready_o(ready), .cts_en_i(cts_en),
    .mp_en_i(mp_en), .two_stop_i(two), .cts_i(cts), .tx_o(tx)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  bit m_busy = 1'b0, m_cts_q = 1'b0;
  bit m_bits[$];
  int m_cnt = 0;

  function automatic bit m_ready();
    return !m_busy && (!cts_en || m_cts_q);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_cts_q = 0; m_cnt = 0; m_bits.delete();
    end else begin
      bit acc;
      acc = valid && m_ready();
      if (m_busy) begin
        if (tick) begin
          if (m_cnt == 15) begin
            m_cnt = 0;
            void'(m_bits.pop_front());
            if (m_bits.size() == 0) m_busy = 0;
          end else m_cnt++;
        end
      end else if (acc) begin
        m_bits.delete();
        m_bits.push_back(1'b0);
        for (int i = 0; i < 8; i++) m_bits.push_back(data[i]);
        if (mp_en) m_bits.push_back(mp);
        m_bits.push_back(1'b1);
        if (two) m_bits.push_back(1'b1);
        m_busy = 1; m_cnt = 0;
      end
      m_cts_q = cts;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit etx;
      etx = m_busy ? m_bits[0] : 1'b1;
      chk(tx === etx, "R2 R4 R5 R11 tx_o vs model", tx, etx);
      chk(ready === m_ready(), "R6 R7 R9 ready_o vs model", ready, m_ready());
    end
  end

  function automatic int frame_len(input bit me, input bit tw);
    return 10 + (me ? 1 : 0) + (tw ? 1 : 0);
  endfunction

  function automatic logic [11:0] frame_vec(input logic [7:0] d, input bit m, input bit me, input bit tw);
    logic [11:0] v;
    int k;
    v = '1;
    v[0] = 1'b0;
    v[8:1] = d;
    k = 9;
    if (me) begin v[9] = m; k = 10; end
    v[k] = 1'b1;
    if (tw) v[k+1] = 1'b1;
    return v;
  endfunction

  // ticks every cycle: one bit = 16 clocks
  task automatic send_cap(input logic [7:0] d, input bit m, input int drop_bit, input string req);
    int n;
    logic [11:0] exp_v, got;
    n = frame_len(mp_en, two);
    exp_v = frame_vec(d, m, mp_en, two);
    got = '1;
    @(negedge clk);
    data = d; mp = m; valid = 1'b1;
    while (!ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    valid = 1'b0;
    repeat (8) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      got[i] = tx;
      if (i == drop_bit) cts = 1'b0;
      if (i == 1) begin mp_en = ~mp_en; two = ~two; end // R11 mid-frame change
      repeat (16) @(negedge clk);
    end
    chk(got === exp_v, req, got, exp_v);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] save_mp;
    int t0, t1;
    repeat (3) @(negedge clk);
    chk(tx === 1'b1, "R1 tx_o idle in reset", tx, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(tx === 1'b1, "R1 tx_o idle after reset", tx, 1);
    chk(ready === 1'b1, "R1 ready after reset", ready, 1);
    tick = 1'b1;

    // R2 plain frame
    mp_en = 0; two = 0;
    send_cap(8'hA5, 0, -1, "R2 8-bit frame LSB first");
    mp_en = 0; two = 0;
    send_cap(8'h01, 1, -1, "R2 frame 0x01");
    // R4 multiprocessor bit
    mp_en = 1; two = 0;
    send_cap(8'h3C, 1, -1, "R4 mp bit after bit7");
    mp_en = 1; two = 0;
    send_cap(8'hFF, 0, -1, "R4 mp bit zero");
    // R5 two stop bits
    mp_en = 0; two = 1;
    send_cap(8'h5A, 0, -1, "R5 two stop bits");

    // R7 cts hold
    mp_en = 0; two = 0;
    @(negedge clk);
    cts_en = 1; cts = 0; data = 8'h77; valid = 1;
    repeat (40) @(negedge clk);
    chk(ready === 1'b0, "R7 held while cts low", ready, 0);
    chk(tx === 1'b1, "R7 line idle while held", tx, 1);
    cts = 1;
    @(negedge clk);
    chk(ready === 1'b1, "R7 ready one clock after cts rise", ready, 1);
    valid = 0;
    @(negedge clk);
    chk(tx === 1'b1, "R7 no accept without valid", tx, 1);

    // R8 cts drop mid-frame
    mp_en = 0; two = 0;
    send_cap(8'hC3, 0, 3, "R8 frame completes after cts drop");
    cts = 1;
    @(negedge clk);

    // R9 cts ignored when disabled
    cts_en = 0; cts = 0;
    @(negedge clk);
    chk(ready === 1'b1, "R9 ready with cts low and gating off", ready, 1);
    mp_en = 0; two = 0;
    send_cap(8'h96, 0, -1, "R9 frame sent with cts low");

    // R10 back-to-back
    mp_en = 0; two = 0;
    @(negedge clk);
    data = 8'h11; valid = 1;
    while (!ready) @(negedge clk);
    t0 = int'($time / 10);
    @(negedge clk);
    while (!ready) @(negedge clk);
    t1 = int'($time / 10);
    valid = 0;
    chk((t1 - t0) == 161, "R10 next accept right after stop", t1 - t0, 161);
    repeat (200) @(negedge clk);

    // R3 no ticks, no progress
    tick = 0;
    @(negedge clk);
    data = 8'h00; valid = 1;
    @(negedge clk);
    valid = 0;
    repeat (50) @(negedge clk);
    chk(tx === 1'b0, "R3 start bit held without ticks", tx, 0);
    tick = 1;
    repeat (200) @(negedge clk);

    // random phase, model compared every clock
    for (int c = 0; c < 6000; c++) begin
      @(negedge clk);
      tick   = ($urandom_range(2) == 0);
      valid  = ($urandom_range(3) != 0);
      data   = 8'($urandom);
      mp     = 1'($urandom);
      cts    = ($urandom_range(4) != 0);
      if ($urandom_range(7) == 0) cts_en = 1'($urandom);
      if ($urandom_range(5) == 0) mp_en  = 1'($urandom);
      if ($urandom_range(5) == 0) two    = 1'($urandom);
    end
    valid = 0; tick = 1;
    repeat (300) @(negedge clk);
    chk(tx === 1'b1, "R2 line idle at end", tx, 1);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule